// File: doc/BRIEF.md
# Low-Power Exit Debug Handshake

This block stalls a chip's return from a low-power state until an attached debugger has agreed that the return may go on. Two requesters can start it. The mode controller raises one request while it leaves a halt or stop state. The reset controller raises the other while it runs the reset sequence that follows a standby exit. While the block waits for a request, it drives the debug data-out pad high. When a request arrives, it pulls that pad low to tell the debugger. It then keeps the acknowledge low until the debugger's sync bit has been seen through a two-flop synchronizer.

After the acknowledge goes high, it stays high for as long as either request is still asserted. Once both requests have dropped, the pad returns high and the block is ready for the next exit. When no debugger is attached (`dbg_en` low), the block steps aside: the acknowledge follows the requests combinationally and the pad driver is turned off. The debugger clears its sync bit through its own write path. Its clock should stay stopped from that clear until it detects the falling edge on the data-out line.

Top module: `lp_exit_dbg_sync`

## Requirements
- R1: After reset with `dbg_en` high, `exit_ack` is 0, `tdo_out` is 1 and `tdo_oe` is 1.
- R2: With `dbg_en` high and neither request asserted, the pad is driven (`tdo_oe`=1) at logic 1 and `exit_ack` is 0.
- R3: A halt/stop exit request (`halt_exit_req`=1) sampled at a clock edge in the idle state drives `tdo_out` to 0 from that edge on.
- R4: A standby-exit indication (`stby_exit_req`=1) sampled in the idle state drives `tdo_out` to 0 from that edge on, in the same way as R3.
- R5: `exit_ack` stays 0 until `dbg_sync` has passed the two synchronizer flops. If `dbg_sync` first rises d cycles after the request is first sampled (d ≥ 1), `exit_ack` rises at the third clock edge after `dbg_sync` is first sampled high, which is d+3 edges after the request.
- R6: While `dbg_en` is high, `exit_ack` stays 1 as long as either request is 1, even after `dbg_sync` is cleared.
- R7: While `exit_ack` is 1, the first edge at which both requests are 0 returns the block to idle: `exit_ack` becomes 0 and `tdo_out` becomes 1.
- R8: While `dbg_en` is high and `exit_ack` is 1, the pad is driven at logic 0.
- R9: With `dbg_en` low, `exit_ack` equals `halt_exit_req | stby_exit_req` without a clock edge, and `tdo_oe` is 0.
- R10: If `dbg_sync` is already 1 and synchronized when a request is first sampled, `exit_ack` rises at the second edge after that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | A debugger is attached; when low the handshake is bypassed |
| halt_exit_req | input | 1 | Exit request from the mode controller (halt or stop exit) |
| stby_exit_req | input | 1 | Standby-exit reset sequence in progress, from the reset controller |
| dbg_sync | input | 1 | Debugger sync bit, asynchronous to `clk` |
| exit_ack | output | 1 | Permission for the transition or reset sequence to complete |
| tdo_out | output | 1 | Value for the debug data-out pad |
| tdo_oe | output | 1 | Output enable for the debug data-out pad |

## Verification
The bound checker evaluates five properties on every cycle. The pad must be low whenever the acknowledge is high. The acknowledge must not rise unless the sync input was high two samples earlier. It must hold while a request is pending and release in the cycle after the last request drops. An idle-state request must pull the pad low at once. The exact acknowledge latency for each sync delay, the combinational bypass without a debugger, the reset values and the equal treatment of the two requesters appear only in the bench's sweeps.

// File: rtl/lp_exit_dbg_sync.sv
module lp_exit_dbg_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_en,
  input  logic halt_exit_req,
  input  logic stby_exit_req,
  input  logic dbg_sync,
  output logic exit_ack,
  output logic tdo_out,
  output logic tdo_oe
);

  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK} state_t;

  state_t           state;
  logic [LAST:0]    sync_q;
  logic             sync_seen;
  logic             req_any;

  assign req_any   = halt_exit_req | stby_exit_req;
  assign sync_seen = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[LAST-1:0], dbg_sync};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (!dbg_en) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (req_any)   state <= ST_WAIT;
        ST_WAIT: if (sync_seen) state <= ST_ACK;
        ST_ACK:  if (!req_any)  state <= ST_IDLE;
        default:                state <= ST_IDLE;
      endcase
    end
  end

  assign tdo_out  = (state == ST_IDLE);
  assign tdo_oe   = dbg_en;
  assign exit_ack = dbg_en ? (state == ST_ACK) : req_any;

endmodule

// File: rtl/lp_exit_dbg_sync_chk.sv
module lp_exit_dbg_sync_chk (
  input logic clk,
  input logic rst_n,
  input logic dbg_en,
  input logic halt_exit_req,
  input logic stby_exit_req,
  input logic dbg_sync,
  input logic exit_ack,
  input logic tdo_out,
  input logic tdo_oe
);

  logic req_any;
  assign req_any = halt_exit_req | stby_exit_req;

  AST_PAD_LOW_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en && exit_ack |-> tdo_oe && !tdo_out); // R8

  AST_ACK_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en && $past(dbg_en) && $rose(exit_ack) |-> $past(dbg_sync, 2)); // R5

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en && exit_ack && req_any |=> !dbg_en || exit_ack); // R6

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en && exit_ack && !req_any |=> !dbg_en || (!exit_ack && tdo_out)); // R7

  AST_NOTIFY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en && $past(dbg_en) && $past(tdo_out) && $past(req_any) |-> !tdo_out); // R3

endmodule

bind lp_exit_dbg_sync lp_exit_dbg_sync_chk u_chk (.*);

// File: tb/lp_exit_dbg_sync_test.sv
`timescale 1ns/1ps
module lp_exit_dbg_sync_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_en = 1'b1;
  logic halt_exit_req = 1'b0;
  logic stby_exit_req = 1'b0;
  logic dbg_sync = 1'b0;
  logic exit_ack, tdo_out, tdo_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lp_exit_dbg_sync uut (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en),
    .halt_exit_req(halt_exit_req), .stby_exit_req(stby_exit_req),
    .dbg_sync(dbg_sync), .exit_ack(exit_ack), .tdo_out(tdo_out), .tdo_oe(tdo_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_wait(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_wait(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack", exit_ack, 0);
    chk("R1 tdo", tdo_out, 1);
    chk("R1 oe", tdo_oe, 1);

    for (int src = 0; src < 3; src++) begin
      for (int d = 0; d < 6; d++) begin
        int ex;
        dbg_sync = 1'b0;
        idle_wait(4);
        if (d == 0) begin
          dbg_sync = 1'b1;
          idle_wait(3);
        end
        ex = (d == 0) ? 2 : d + 3;
        halt_exit_req = (src != 1);
        stby_exit_req = (src != 0);
        chk("R2 tdo before edge", tdo_out, 1);
        chk("R2 ack before edge", exit_ack, 0);
        for (int i = 1; i <= d + 6; i++) begin
          @(negedge clk);
          chk(src == 1 ? "R4 tdo low" : "R3 tdo low", tdo_out, 0);
          chk(d == 0 ? "R10 ack timing" : "R5 ack timing", exit_ack, (i >= ex) ? 1 : 0);
          if (d > 0 && i == d) dbg_sync = 1'b1;
        end
        dbg_sync = 1'b0;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk("R6 hold after sync clear", exit_ack, 1);
          chk("R8 pad low", tdo_out, 0);
        end
        if (src == 2) begin
          halt_exit_req = 1'b0;
          @(negedge clk);
          chk("R6 hold one request left", exit_ack, 1);
        end
        halt_exit_req = 1'b0;
        stby_exit_req = 1'b0;
        @(negedge clk);
        chk("R7 ack release", exit_ack, 0);
        chk("R7 tdo high", tdo_out, 1);
      end
    end

    dbg_en = 1'b0;
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        @(negedge clk);
        halt_exit_req = a[0];
        stby_exit_req = b[0];
        #1;
        chk("R9 bypass ack", exit_ack, a | b);
        chk("R9 pad released", tdo_oe, 0);
      end
    end
    halt_exit_req = 1'b0;
    stby_exit_req = 1'b0;
    dbg_en = 1'b1;
    @(negedge clk);
    chk("R2 idle after bypass", tdo_out, 1);
    chk("R2 ack idle", exit_ack, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule